// File: doc/BRIEF.md
# Interleaved Eight-Channel Running Accumulator

The block takes a stream of samples from eight channels that arrive interleaved in round-robin order. Sample number i of the stream belongs to channel i mod 8, so the stream reads ch0, ch1, … ch7, ch0, … . For every sample it accepts, the block adds the sample to that channel's running sum and emits the new sum. The output for stream position 8 is therefore the sum of the first two ch0 samples.

Sums carry over from one frame to the next. A frame is 400 samples per channel, 3200 samples in all. Frames may follow each other with no gap, and only the synchronous clear input zeroes the sums.

A mode input picks one of two ways of feeding the block:
- **Narrow mode:** one sample per cycle on lane 0, and each channel is touched once every eight samples.
- **Wide mode:** one sample of every channel per cycle. Lane k carries channel k, and all eight sums are updated together.

The input side has a valid/ready handshake. The output side has a valid strobe with no backpressure, plus a marker on the output that completes each frame.

Top module: `ilv_acc8`

## Requirements
- R1: After reset, out_valid_o is low and every channel sum is zero. The first sample accepted on any channel produces an output equal to that sample, zero-extended.
- R2: In narrow mode, the k-th accepted sample since reset or clear (k from 0) is added to channel k mod 8 and frame positions advance by one. out_chan_o shows that channel. Lane 0 of out_sum_o (bits 31:0) carries the channel's new sum, and lanes 1 to 7 are zero.
- R3: An input accepted on a clock edge (in_valid_i and in_ready_o both high) produces out_valid_o high after that edge and before the next one. Outputs leave in the order the inputs were accepted.
- R4: In wide mode, the samples in_data_i[16k+15:16k] for k = 0..7 are added to channel k, and frame positions advance by eight. Lane k of out_sum_o, at bits [32k+31:32k], carries channel k's new sum. out_wide_o is high and out_chan_o is 0.
- R5: Sums are not reset when a frame ends. The first output of a new frame includes everything accumulated before it.
- R6: Sums are 32 bits wide, treat samples as unsigned, and wrap modulo 2^32 with no saturation.
- R7: out_last_o is high on the output of the beat that brings the frame position to 3200, which is 8 × FRAME_LEN. In narrow mode this is every 3200th sample, and in wide mode every 400th beat. The position then restarts at channel 0.
- R8: While clear_i is high, in_ready_o is low and no input is taken. All sums become zero, the frame position returns to channel 0, and out_valid_o is low on the following cycle.
- R9: in_ready_o is high in every cycle that clear_i is low, so consecutive frames need no idle cycles.
- R10: A cycle with in_valid_i low changes no sum and no frame position, and produces no output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all sums and of the frame position |
| wide_mode_i | input | 1 | 0: one sample per cycle on lane 0; 1: one sample per channel per cycle |
| in_valid_i | input | 1 | Input sample(s) present |
| in_ready_o | output | 1 | Block accepts input this cycle |
| in_data_i | input | 128 | Eight 16-bit lanes; lane k at bits [16k+15:16k] |
| out_valid_o | output | 1 | Output sums valid |
| out_wide_o | output | 1 | Output came from a wide-mode beat |
| out_chan_o | output | 3 | Channel of lane 0 in narrow mode, 0 in wide mode |
| out_last_o | output | 1 | Output completes a frame |
| out_sum_o | output | 256 | Eight 32-bit sums; lane k at bits [32k+31:32k] |

## Verification
Every result appears exactly one clock after the edge that accepts its input: the sums, the channel, the mode flag and the frame marker all come from the same register stage. in_ready_o is combinational from clear_i and can be checked within the same cycle. The bench drives inputs on the falling edge and checks in_ready_o shortly afterwards. A behavioural model then computes what the next rising edge must produce, and the bench compares every output at the following falling edge. The effect of a clear or an idle cycle therefore shows up in the very next comparison, as a low valid, and in the sums of the next accepted sample.

// File: rtl/ilv_acc8_pkg.sv
package ilv_acc8_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  typedef logic [CH_W-1:0] chan_t;
endpackage

// File: rtl/ilv_acc8_pos.sv
module ilv_acc8_pos
  import ilv_acc8_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 400
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  adv_i,
  input  logic  wide_i,
  output chan_t chan_o,
  output logic  last_o
);
  localparam int unsigned TOTAL = NUM_CH * FRAME_LEN;
  localparam int unsigned POS_W = $clog2(TOTAL + NUM_CH + 1);

  logic [POS_W-1:0] pos_q, pos_next;

  assign pos_next = pos_q + (wide_i ? POS_W'(NUM_CH) : POS_W'(1));
  assign last_o   = (pos_next >= POS_W'(TOTAL));
  assign chan_o   = pos_q[CH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (clear_i) pos_q <= '0;
    else if (adv_i)   pos_q <= last_o ? '0 : pos_next;
  end

  assert_pos_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < POS_W'(TOTAL));
  assert_frame_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_o && !clear_i) |=> (pos_q == '0));
  assert_pos_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clear_i) |=> $stable(pos_q));
  assert_pos_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pos_q == '0));
endmodule

// File: rtl/ilv_acc8_lane.sv
module ilv_acc8_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SUM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_en_i,
  input  logic [DATA_W-1:0] add_val_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [SUM_W-1:0] acc_q;

  // unsigned add, wraps modulo 2^SUM_W
  assign sum_o = acc_q + SUM_W'(add_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clear_i)  acc_q <= '0;
    else if (add_en_i) acc_q <= sum_o;
  end

  assert_acc_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0));
  assert_acc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !add_en_i) |=> $stable(acc_q));
endmodule

// File: rtl/ilv_acc8.sv
module ilv_acc8
  import ilv_acc8_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SUM_W     = 32,
  parameter int unsigned FRAME_LEN = 400
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     wide_mode_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [NUM_CH*DATA_W-1:0] in_data_i,
  output logic                     out_valid_o,
  output logic                     out_wide_o,
  output logic [CH_W-1:0]          out_chan_o,
  output logic                     out_last_o,
  output logic [NUM_CH*SUM_W-1:0]  out_sum_o
);
  logic             accept;
  chan_t            cur_chan;
  logic             frame_last;
  logic [SUM_W-1:0] lane_sum [NUM_CH];

  assign in_ready_o = ~clear_i;
  assign accept     = in_valid_i & in_ready_o;

  ilv_acc8_pos #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .adv_i   (accept),
    .wide_i  (wide_mode_i),
    .chan_o  (cur_chan),
    .last_o  (frame_last)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    logic              en;
    logic [DATA_W-1:0] val;
    assign en  = accept & (wide_mode_i | (cur_chan == chan_t'(k)));
    assign val = wide_mode_i ? in_data_i[k*DATA_W +: DATA_W] : in_data_i[DATA_W-1:0];
    ilv_acc8_lane #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (clear_i),
      .add_en_i  (en),
      .add_val_i (val),
      .sum_o     (lane_sum[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_wide_o  <= 1'b0;
      out_chan_o  <= '0;
      out_last_o  <= 1'b0;
      out_sum_o   <= '0;
    end else begin
      out_valid_o <= accept;
      out_last_o  <= accept & frame_last;
      if (accept) begin
        out_wide_o <= wide_mode_i;
        out_chan_o <= wide_mode_i ? '0 : cur_chan;
        for (int k = 0; k < NUM_CH; k++) begin
          if (wide_mode_i) out_sum_o[k*SUM_W +: SUM_W] <= lane_sum[k];
          else if (k == 0) out_sum_o[k*SUM_W +: SUM_W] <= lane_sum[cur_chan];
          else             out_sum_o[k*SUM_W +: SUM_W] <= '0;
        end
      end
    end
  end

  assert_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);
  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !out_valid_o);
  assert_clear_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !out_valid_o);
  assert_narrow_upper_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_wide_o) |-> (out_sum_o[NUM_CH*SUM_W-1:SUM_W] == '0));
  assert_wide_chan_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_wide_o) |-> (out_chan_o == '0));
  assert_last_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
endmodule

// File: tb/ilv_acc8_test.sv
module ilv_acc8_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int DW    = 16;
  localparam int SW    = 32;
  localparam int FRAME = 400;
  localparam int TOTAL = NCH * FRAME;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, wide_mode_i = 1'b0, in_valid_i = 1'b0;
  logic [NCH*DW-1:0] in_data_i = '0;
  logic in_ready_o, out_valid_o, out_wide_o, out_last_o;
  logic [2:0] out_chan_o;
  logic [NCH*SW-1:0] out_sum_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ilv_acc8 #(.DATA_W(DW), .SUM_W(SW), .FRAME_LEN(FRAME)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .wide_mode_i(wide_mode_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_wide_o(out_wide_o), .out_chan_o(out_chan_o),
    .out_last_o(out_last_o), .out_sum_o(out_sum_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic [SW-1:0] m_acc [NCH];
  int m_pos = 0;
  logic e_valid = 0, e_wide = 0, e_last = 0;
  logic [2:0] e_chan = '0;
  logic [NCH*SW-1:0] e_sum = '0;

  task automatic chk(input bit ok, input string tag, input logic [NCH*SW-1:0] act,
                     input logic [NCH*SW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit w, input bit c, input logic [NCH*DW-1:0] dat);
    clear_i = c; wide_mode_i = w; in_valid_i = v; in_data_i = dat;
    #1;
    chk(in_ready_o == !c, c ? "R8" : "R9", {255'd0, in_ready_o}, {255'd0, !c});
    e_valid = 0; e_last = 0;
    if (c) begin
      for (int k = 0; k < NCH; k++) m_acc[k] = '0;
      m_pos = 0;
    end else if (v) begin
      e_valid = 1; e_wide = w; e_sum = '0;
      if (w) begin
        for (int k = 0; k < NCH; k++) begin
          m_acc[k] = m_acc[k] + SW'(dat[k*DW +: DW]);
          e_sum[k*SW +: SW] = m_acc[k];
        end
        e_chan = 3'd0;
        m_pos += NCH;
      end else begin
        e_chan = 3'(m_pos % NCH);
        m_acc[m_pos % NCH] = m_acc[m_pos % NCH] + SW'(dat[DW-1:0]);
        e_sum[SW-1:0] = m_acc[m_pos % NCH];
        m_pos += 1;
      end
      if (m_pos >= TOTAL) begin e_last = 1; m_pos = 0; end
    end
    @(negedge clk_i);
    chk(out_valid_o == e_valid, c ? "R8" : (v ? "R3" : "R10"), {255'd0, out_valid_o}, {255'd0, e_valid});
    if (e_valid) begin
      chk(out_sum_o == e_sum, cur_tag, out_sum_o, e_sum);
      chk(out_chan_o == e_chan, e_wide ? "R4" : "R2", {253'd0, out_chan_o}, {253'd0, e_chan});
      chk(out_wide_o == e_wide, e_wide ? "R4" : "R2", {255'd0, out_wide_o}, {255'd0, e_wide});
      chk(out_last_o == e_last, "R7", {255'd0, out_last_o}, {255'd0, e_last});
    end
  endtask

  function automatic logic [NCH*DW-1:0] wide_pat(input int i);
    logic [NCH*DW-1:0] r;
    for (int k = 0; k < NCH; k++) r[k*DW +: DW] = DW'(i * 29 + k * 1000 + 3);
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) m_acc[k] = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(out_valid_o == 1'b0, "R1", {255'd0, out_valid_o}, '0);
    chk(out_sum_o == '0, "R1", out_sum_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cur_tag = "R1";
    for (int i = 0; i < 8; i++) step(1, 0, 0, (NCH*DW)'(i * 3 + 1));
    cur_tag = "R2";
    for (int i = 0; i < 24; i++) step(1, 0, 0, (NCH*DW)'((i * 37 + 5) & 16'hffff));
    cur_tag = "R10";
    for (int i = 0; i < 48; i++) step(i % 3 != 0, 0, 0, (NCH*DW)'(i * 11 + 2));
    // R5/R7: cross a frame boundary in narrow mode
    cur_tag = "R5";
    for (int i = 0; i < TOTAL + 16; i++) step(1, 0, 0, (NCH*DW)'((i * 13 + 7) & 16'hffff));
    // R8: clear with valid held high
    cur_tag = "R8";
    step(1, 0, 1, (NCH*DW)'(16'h1234));
    for (int i = 0; i < 8; i++) step(1, 0, 0, (NCH*DW)'(100 + i));
    cur_tag = "R4";
    for (int i = 0; i < 24; i++) step(1, 1, 0, wide_pat(i));
    cur_tag = "R7";
    for (int i = 0; i < 379; i++) step(1, 1, 0, wide_pat(i + 50));
    // R6: wrap of the 32-bit sums
    cur_tag = "R6";
    step(0, 1, 1, '0);
    for (int i = 0; i < 65540; i++) step(1, 1, 0, {NCH{16'hffff}});
    cur_tag = "R2";
    for (int i = 0; i < 8; i++) step(1, 0, 0, (NCH*DW)'(i + 9));
    step(0, 0, 0, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule